// File: doc/BRIEF.md
# DMA Descriptor Fault Checker

This block sits beside a DMA channel engine. It checks a channel's transfer-control descriptor in the same cycle the channel is activated. A descriptor that breaks the alignment, byte-count, size-encoding or priority rules is treated as inconsistent. For such a descriptor the block withholds the transfer-start strobe, so the engine never begins the move. Error terminations reported by the read and write master ports of a transfer already in progress are folded into the same status register as the descriptor faults.

The status register records one bit per fault cause, the number of the failing channel and a valid flag. The first error is held until software clears it with a write-one-to-clear strobe. Any error that arrives while one is still held sets a sticky overflow flag.

Top module: `dma_fault_chk`

## Requirements
- R1: Transfer sizes use a 3-bit code: 0..5 select 1, 2, 4, 8, 16 and 32 bytes. Codes 6 and 7 are illegal. An illegal source code sets cause bit 0 and an illegal destination code sets cause bit 1. An illegal code adds no offset or byte-count fault.
- R2: A source start address that is not a multiple of the source transfer size sets cause bit 0.
- R3: A destination start address that is not a multiple of the destination transfer size sets cause bit 1.
- R4: A signed source offset that is not a multiple of the source size sets cause bit 2. The same rule for the destination offset sets cause bit 3. Negative offsets follow the same rule.
- R5: A minor-loop byte count that is not a multiple of both the source and the destination transfer size sets cause bit 4.
- R6: When fixed arbitration is selected, two or more channels sharing a priority value set cause bit 5. In round-robin mode priorities are never checked.
- R7: An activation with no descriptor fault raises `start_o` for exactly one cycle on the next clock edge, with `start_ch_o` equal to the activated channel. An activation with any descriptor fault leaves `start_o` low.
- R8: A read bus error sets cause bit 6 and a write bus error sets cause bit 7. Either one latches `bus_ch` as the failing channel.
- R9: The first error sets `stat_valid_o` and latches its cause bits and channel one edge later. These hold until cleared. Any later error while they are held sets `stat_ovf_o`, which stays set.
- R10: A `clr` pulse with no new error clears the valid flag, the cause bits, the channel and the overflow flag. A new error arriving in the same cycle as `clr` is loaded instead, with the overflow flag cleared.
- R11: After reset all status outputs and `start_o` are zero.
- R12: When a descriptor fault and a bus error arrive in the same cycle, the descriptor fault and the activated channel are recorded and the overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Channel activation request this cycle |
| act_ch | input | CH_W | Channel being activated |
| src_addr | input | ADDR_W | Source start address |
| dst_addr | input | ADDR_W | Destination start address |
| src_ofs | input | OFS_W | Signed source offset |
| dst_ofs | input | OFS_W | Signed destination offset |
| minor_bytes | input | NB_W | Minor-loop byte count |
| src_size | input | 3 | Source transfer size code |
| dst_size | input | 3 | Destination transfer size code |
| fixed_arb | input | 1 | 1 = fixed-priority arbitration, 0 = round-robin |
| prio_flat | input | NUM_CH*PRIO_W | Channel priorities, channel i at bits [i*PRIO_W +: PRIO_W] |
| rd_err | input | 1 | Read master error termination |
| wr_err | input | 1 | Write master error termination |
| bus_ch | input | CH_W | Channel owning the faulted bus cycle |
| clr | input | 1 | Write-one-to-clear strobe for the status register |
| start_o | output | 1 | Registered transfer-start strobe |
| start_ch_o | output | CH_W | Channel of the start strobe |
| stat_valid_o | output | 1 | An error is latched |
| stat_cause_o | output | 8 | Cause bits (see R1 to R8) |
| stat_ch_o | output | CH_W | Channel of the latched error |
| stat_ovf_o | output | 1 | Sticky overflow: a further error occurred |

## Verification
The assertions check on every cycle that a latched error holds steady until cleared, that a further error sets the overflow flag, that a lone clear empties the register, and that the start strobe follows the descriptor verdict. Only the bench's sweeps show that each alignment, byte-count, size-code and priority rule selects the correct cause bit. The sweeps cover every size code against a range of addresses, offsets and counts, and every priority pattern of a four-channel setup. The ordering cases also need directed scenarios: a clear arriving together with a new error, and a descriptor fault arriving together with a bus error.

// File: rtl/dma_fault_pkg.sv
package dma_fault_pkg;

  localparam int CAUSE_N   = 8;
  localparam int SIZE_W    = 3;
  localparam int MASK_W    = 6;

  localparam int C_SADDR   = 0;
  localparam int C_DADDR   = 1;
  localparam int C_SOFS    = 2;
  localparam int C_DOFS    = 3;
  localparam int C_NBYTES  = 4;
  localparam int C_PRIO    = 5;
  localparam int C_RDBUS   = 6;
  localparam int C_WRBUS   = 7;

  function automatic logic size_legal(input logic [SIZE_W-1:0] code);
    return code <= 3'd5;
  endfunction

  // low-bit mask that must be zero for alignment; zero for illegal codes
  function automatic logic [MASK_W-1:0] size_mask(input logic [SIZE_W-1:0] code);
    logic [MASK_W-1:0] m;
    case (code)
      3'd0:    m = 6'h00;
      3'd1:    m = 6'h01;
      3'd2:    m = 6'h03;
      3'd3:    m = 6'h07;
      3'd4:    m = 6'h0F;
      3'd5:    m = 6'h1F;
      default: m = 6'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dma_desc_check.sv
module dma_desc_check
  import dma_fault_pkg::*;
(
  input  logic [MASK_W-1:0] src_lo,
  input  logic [MASK_W-1:0] dst_lo,
  input  logic [MASK_W-1:0] sofs_lo,
  input  logic [MASK_W-1:0] dofs_lo,
  input  logic [MASK_W-1:0] nb_lo,
  input  logic [SIZE_W-1:0] src_size,
  input  logic [SIZE_W-1:0] dst_size,
  output logic [4:0]        fault_o
);

  logic [MASK_W-1:0] smask, dmask;

  always_comb begin
    smask = size_mask(src_size);
    dmask = size_mask(dst_size);
    fault_o[C_SADDR]  = !size_legal(src_size) || |(src_lo & smask);
    fault_o[C_DADDR]  = !size_legal(dst_size) || |(dst_lo & dmask);
    fault_o[C_SOFS]   = |(sofs_lo & smask);
    fault_o[C_DOFS]   = |(dofs_lo & dmask);
    fault_o[C_NBYTES] = |(nb_lo & (smask | dmask));
  end

endmodule

// File: rtl/dma_prio_check.sv
module dma_prio_check #(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 2
) (
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  input  logic                     fixed_arb,
  output logic                     dup_o
);

  localparam int PAIR_N = NUM_CH * NUM_CH;

  logic [PAIR_N-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_row
      for (genvar j = 0; j < NUM_CH; j++) begin : g_col
        if (j > i) begin : g_cmp
          assign hit[i*NUM_CH+j] =
            prio_flat[i*PRIO_W +: PRIO_W] == prio_flat[j*PRIO_W +: PRIO_W];
        end else begin : g_none
          assign hit[i*NUM_CH+j] = 1'b0;
        end
      end
    end
  endgenerate

  assign dup_o = fixed_arb && |hit;

endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
  import dma_fault_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_fail,
  input  logic [5:0]         cfg_cause,
  input  logic [CH_W-1:0]    act_ch,
  input  logic               rd_err,
  input  logic               wr_err,
  input  logic [CH_W-1:0]    bus_ch,
  input  logic               clr,
  output logic               valid_o,
  output logic [CAUSE_N-1:0] cause_o,
  output logic [CH_W-1:0]    ch_o,
  output logic               ovf_o
);

  logic               bus_any, new_err, dual;
  logic [CAUSE_N-1:0] new_cause;
  logic [CH_W-1:0]    new_ch;

  always_comb begin
    bus_any   = rd_err || wr_err;
    new_err   = cfg_fail || bus_any;
    dual      = cfg_fail && bus_any;
    new_cause = cfg_fail ? {2'b00, cfg_cause} : {wr_err, rd_err, 6'b0};
    new_ch    = cfg_fail ? act_ch : bus_ch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      cause_o <= '0;
      ch_o    <= '0;
      ovf_o   <= 1'b0;
    end else if (new_err && (!valid_o || clr)) begin
      valid_o <= 1'b1;
      cause_o <= new_cause;
      ch_o    <= new_ch;
      ovf_o   <= dual;
    end else if (new_err) begin
      ovf_o   <= 1'b1;
    end else if (clr) begin
      valid_o <= 1'b0;
      cause_o <= '0;
      ch_o    <= '0;
      ovf_o   <= 1'b0;
    end
  end

  // R9: a held error stays put until cleared
  assert_hold_first_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o && !clr |=> valid_o && $stable(cause_o) && $stable(ch_o));

  // R9: a further error while one is held sets overflow
  assert_ovf_sets_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o && !clr && (cfg_fail || rd_err || wr_err) |=> ovf_o);

  // R10: a lone clear empties the register
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
    clr && !cfg_fail && !rd_err && !wr_err |=> !valid_o && !ovf_o && cause_o == '0);

endmodule

// File: rtl/dma_fault_chk.sv
module dma_fault_chk
  import dma_fault_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int OFS_W  = 16,
  parameter  int NB_W   = 32,
  parameter  int NUM_CH = 4,
  parameter  int PRIO_W = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     act_valid,
  input  logic [CH_W-1:0]          act_ch,
  input  logic [ADDR_W-1:0]        src_addr,
  input  logic [ADDR_W-1:0]        dst_addr,
  input  logic signed [OFS_W-1:0]  src_ofs,
  input  logic signed [OFS_W-1:0]  dst_ofs,
  input  logic [NB_W-1:0]          minor_bytes,
  input  logic [SIZE_W-1:0]        src_size,
  input  logic [SIZE_W-1:0]        dst_size,
  input  logic                     fixed_arb,
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  input  logic                     rd_err,
  input  logic                     wr_err,
  input  logic [CH_W-1:0]          bus_ch,
  input  logic                     clr,
  output logic                     start_o,
  output logic [CH_W-1:0]          start_ch_o,
  output logic                     stat_valid_o,
  output logic [CAUSE_N-1:0]       stat_cause_o,
  output logic [CH_W-1:0]          stat_ch_o,
  output logic                     stat_ovf_o
);

  logic [4:0] desc_fault;
  logic       prio_dup;
  logic [5:0] cfg_cause;
  logic       cfg_fail;
  logic       unused_hi;

  assign unused_hi = ^{src_addr[ADDR_W-1:MASK_W], dst_addr[ADDR_W-1:MASK_W],
                       src_ofs[OFS_W-1:MASK_W], dst_ofs[OFS_W-1:MASK_W],
                       minor_bytes[NB_W-1:MASK_W]};

  dma_desc_check u_desc (
    .src_lo   (src_addr[MASK_W-1:0]),
    .dst_lo   (dst_addr[MASK_W-1:0]),
    .sofs_lo  (src_ofs[MASK_W-1:0]),
    .dofs_lo  (dst_ofs[MASK_W-1:0]),
    .nb_lo    (minor_bytes[MASK_W-1:0]),
    .src_size (src_size),
    .dst_size (dst_size),
    .fault_o  (desc_fault)
  );

  dma_prio_check #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_prio (
    .prio_flat (prio_flat),
    .fixed_arb (fixed_arb),
    .dup_o     (prio_dup)
  );

  assign cfg_cause = act_valid ? {prio_dup, desc_fault} : 6'b0;
  assign cfg_fail  = |cfg_cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o    <= 1'b0;
      start_ch_o <= '0;
    end else begin
      start_o    <= act_valid && !cfg_fail;
      start_ch_o <= act_ch;
    end
  end

  dma_err_status #(.CH_W(CH_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .cfg_fail  (cfg_fail),
    .cfg_cause (cfg_cause),
    .act_ch    (act_ch),
    .rd_err    (rd_err),
    .wr_err    (wr_err),
    .bus_ch    (bus_ch),
    .clr       (clr),
    .valid_o   (stat_valid_o),
    .cause_o   (stat_cause_o),
    .ch_o      (stat_ch_o),
    .ovf_o     (stat_ovf_o)
  );

  // R7: a faulty descriptor never starts
  assert_no_start_on_fault_R7: assert property (@(posedge clk) disable iff (rst)
    act_valid && cfg_fail |=> !start_o);

  // R7: a clean descriptor starts on the named channel
  assert_start_on_pass_R7: assert property (@(posedge clk) disable iff (rst)
    act_valid && !cfg_fail |=> start_o && start_ch_o == $past(act_ch));

  // R7: no activation, no start
  assert_start_needs_act_R7: assert property (@(posedge clk) disable iff (rst)
    !act_valid |=> !start_o);

endmodule

// File: tb/sim_dma_fault_chk.sv
module sim_dma_fault_chk;

  localparam int NCH = 4;
  localparam int PW  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_valid = 1'b0;
  logic [1:0]  act_ch = '0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic signed [15:0] src_ofs = '0, dst_ofs = '0;
  logic [31:0] minor_bytes = '0;
  logic [2:0]  src_size = '0, dst_size = '0;
  logic        fixed_arb = 1'b0;
  logic [7:0]  prio_flat = '0;
  logic        rd_err = 1'b0, wr_err = 1'b0;
  logic [1:0]  bus_ch = '0;
  logic        clr = 1'b0;
  logic        start_o;
  logic [1:0]  start_ch_o;
  logic        stat_valid_o;
  logic [7:0]  stat_cause_o;
  logic [1:0]  stat_ch_o;
  logic        stat_ovf_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_fault_chk #(.NUM_CH(NCH), .PRIO_W(PW)) u0 (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_ch(act_ch),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_ofs(src_ofs), .dst_ofs(dst_ofs),
    .minor_bytes(minor_bytes), .src_size(src_size), .dst_size(dst_size),
    .fixed_arb(fixed_arb), .prio_flat(prio_flat), .rd_err(rd_err), .wr_err(wr_err),
    .bus_ch(bus_ch), .clr(clr), .start_o(start_o), .start_ch_o(start_ch_o),
    .stat_valid_o(stat_valid_o), .stat_cause_o(stat_cause_o),
    .stat_ch_o(stat_ch_o), .stat_ovf_o(stat_ovf_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one clock cycle with the given strobes; outputs sampled 1 ns after the edge
  task automatic cycle(input logic av, input logic cl, input logic rd,
                       input logic wr, input logic [1:0] bch);
    @(negedge clk);
    act_valid = av; clr = cl; rd_err = rd; wr_err = wr; bus_ch = bch;
    @(posedge clk);
    #1;
    act_valid = 1'b0; clr = 1'b0; rd_err = 1'b0; wr_err = 1'b0;
  endtask

  function automatic int bytes_of(input int code);
    return (code <= 5) ? (1 << code) : 0;
  endfunction

  function automatic bit misal(input int v, input int b);
    return (b != 0) && ((v % b) != 0);
  endfunction

  // packed view of outputs: {start, start_ch, valid, cause} for the sweeps
  function automatic int snap();
    return {start_o, start_ch_o, stat_valid_o, stat_cause_o};
  endfunction

  function automatic int expect_snap(input int cause, input int ch);
    bit ok;
    ok = (cause == 0);
    return {ok, ok ? ch[1:0] : start_ch_o, !ok, cause[7:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11: reset state
    check("R11", {start_o, stat_valid_o, stat_cause_o, stat_ch_o, stat_ovf_o}, 0);

    // R1 R2 R4 R7: source size codes against addresses and offsets
    for (int ss = 0; ss < 8; ss++) begin
      for (int a = 0; a < 64; a++) begin
        int sb, cause;
        sb = bytes_of(ss);
        src_size = 3'(ss); src_addr = 32'(a); src_ofs = 16'(a - 32);
        dst_size = 3'd0; dst_addr = 32'd0; dst_ofs = 16'sd0;
        minor_bytes = 32'd64; fixed_arb = 1'b0; act_ch = 2'(a % 4);
        cause = 0;
        if (ss > 5 || misal(a, sb)) cause |= 1;
        if (misal(a - 32, sb))      cause |= 4;
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
        check("R1/R2/R4/R7 src sweep", snap(), expect_snap(cause, a % 4));
      end
    end

    // R1 R3 R4 R5: destination size codes against addresses, offsets, counts
    for (int ds = 0; ds < 8; ds++) begin
      for (int b = 0; b < 64; b++) begin
        int db, cause;
        db = bytes_of(ds);
        src_size = 3'd0; src_addr = 32'd0; src_ofs = 16'sd0;
        dst_size = 3'(ds); dst_addr = 32'(b); dst_ofs = 16'(2*b - 64);
        minor_bytes = 32'(b ^ 8); act_ch = 2'(b % 4);
        cause = 0;
        if (ds > 5 || misal(b, db))  cause |= 2;
        if (misal(2*b - 64, db))     cause |= 8;
        if (misal(b ^ 8, db))        cause |= 16;
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
        check("R1/R3/R4/R5 dst sweep", snap(), expect_snap(cause, b % 4));
      end
    end

    // R5: byte count against the source size
    for (int ss = 0; ss < 6; ss++) begin
      for (int m = 0; m < 64; m++) begin
        int cause;
        src_size = 3'(ss); dst_size = 3'd0; src_addr = 32'd0; dst_addr = 32'd0;
        src_ofs = 16'sd0; dst_ofs = 16'sd0; minor_bytes = 32'(m); act_ch = 2'd1;
        cause = misal(m, bytes_of(ss)) ? 16 : 0;
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
        check("R5 src count", snap(), expect_snap(cause, 1));
      end
    end

    // R6: every priority pattern, both arbitration modes
    src_size = 3'd0; dst_size = 3'd0; minor_bytes = 32'd4;
    for (int mode = 0; mode < 2; mode++) begin
      for (int p = 0; p < 256; p++) begin
        int dup, cause;
        dup = 0;
        for (int i = 0; i < NCH; i++)
          for (int j = i + 1; j < NCH; j++)
            if (((p >> (2*i)) & 3) == ((p >> (2*j)) & 3)) dup = 1;
        fixed_arb = mode[0]; prio_flat = 8'(p); act_ch = 2'd2;
        cause = (mode == 1 && dup == 1) ? 32 : 0;
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
        check("R6 priority", snap(), expect_snap(cause, 2));
      end
    end
    fixed_arb = 1'b0; prio_flat = 8'h00;

    // R8 R9 R10: bus errors, holding, overflow, clearing
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    check("R10 clear", {stat_valid_o, stat_ovf_o}, 0);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
    check("R8 read bus", {stat_valid_o, stat_cause_o, stat_ch_o, stat_ovf_o},
          {1'b1, 8'h40, 2'd2, 1'b0});
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 2'd1);
    check("R9 hold+ovf", {stat_valid_o, stat_cause_o, stat_ch_o, stat_ovf_o},
          {1'b1, 8'h40, 2'd2, 1'b1});
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R9 ovf sticky", {stat_valid_o, stat_cause_o, stat_ovf_o}, {1'b1, 8'h40, 1'b1});
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 2'd3);
    check("R10 new wins", {stat_valid_o, stat_cause_o, stat_ch_o, stat_ovf_o},
          {1'b1, 8'h80, 2'd3, 1'b0});
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
    check("R9 first kept", {stat_cause_o, stat_ch_o, stat_ovf_o}, {8'h80, 2'd3, 1'b1});
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    check("R10 clear all", {stat_valid_o, stat_cause_o, stat_ch_o, stat_ovf_o}, 0);
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 2'd1);
    check("R8 both bus", {stat_cause_o, stat_ch_o, stat_ovf_o}, {8'hC0, 2'd1, 1'b0});

    // R12: descriptor fault and bus error together
    src_addr = 32'd1; src_size = 3'd2; act_ch = 2'd3;
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 2'd1);
    check("R12 dual", {start_o, stat_valid_o, stat_cause_o, stat_ch_o, stat_ovf_o},
          {1'b0, 1'b1, 8'h01, 2'd3, 1'b1});

    // R7 R9: clean start while an error is held leaves status alone
    src_addr = 32'd0; act_ch = 2'd0;
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R7 clean start", {start_o, start_ch_o, stat_cause_o, stat_ch_o},
          {1'b1, 2'd0, 8'h01, 2'd3});
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R7 single pulse", start_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule